// File: doc/BRIEF.md
# Single-Wire Bus Master Engine

This block is the master side of an open-drain single-wire bus. A host hands it one command at a time: a bus reset with presence detection, a byte write, a byte read, a single-bit write or a single-bit read. The engine turns each command into timed low pulses on the line and samples the line through a two-flop synchronizer. The pad is modelled as a drive-low enable plus a sampled input. All timing is counted in microseconds, derived from a clock-cycles-per-microsecond parameter.

A write command can also ask for a strong pullup. Once the last slot of the command is over, the engine raises the pullup enable for a hold time given in microseconds, and it keeps the bus quiet until the hold time ends. The host sees `busy` while a command runs. A one-cycle `done` strobe marks completion, and it carries the presence result of a reset command.

The state machine has seven states:
- `ST_IDLE`: waits for a command.
- `ST_RST_LOW`: drives the reset pulse.
- `ST_RST_LISTEN`: the line is released and the engine watches the presence window.
- `ST_SLOT_LOW`: the low part of a slot.
- `ST_SLOT_REL`: the released part of a slot, which holds the read sample point.
- `ST_RECOVER`: released-high gap between slots.
- `ST_PULLUP`: strong pullup hold.

Transitions:
- `ST_IDLE` goes to `ST_RST_LOW` on a reset command, or to `ST_SLOT_LOW` on any bit or byte command.
- `ST_RST_LOW` goes to `ST_RST_LISTEN`, and `ST_RST_LISTEN` goes back to `ST_IDLE` with `done`.
- `ST_SLOT_LOW` goes to `ST_SLOT_REL`, then to `ST_RECOVER`.
- `ST_RECOVER` goes to one of three states. It goes to `ST_SLOT_LOW` if byte bits remain. Otherwise it goes to `ST_PULLUP` if a write asked for the pullup, and to `ST_IDLE` with `done` in every other case.
- `ST_PULLUP` goes to `ST_IDLE` with `done`.

Top module: `sw_bus_master`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `line_drive_low`, `pullup_en`, `presence`, `no_device` and `rd_data` are all 0.
- R2: A reset command (`cmd_op` = 0) drives the line low for RST_LOW_US (480 µs). It then releases the line for RST_LISTEN_US (480 µs), and `done` rises as the listen time ends.
- R3: During the listen time, a low line seen from PRES_OPEN_US (15 µs) up to but not including PRES_CLOSE_US (75 µs) after release counts as presence. In that case the reset command completes with `presence`=1 and `no_device`=0. Otherwise it completes with `presence`=0 and `no_device`=1. Both flags hold until the next reset command.
- R4: A 1 bit is written by a low pulse of SHORT_LOW_US (2 µs). Within a byte, successive slots begin every SLOT_US+RECOVERY_US (67 µs), so each slot ends in released-high recovery.
- R5: A 0 bit is written by a low pulse of WR0_LOW_US (60 µs).
- R6: A read slot drives low for 2 µs, then samples the line at SAMPLE_US (13 µs) after the slot began. A low sample reads 0 and a high sample reads 1. A read-bit command (`cmd_op` = 4) places the bit in `rd_data[7]`.
- R7: A write-byte command (`cmd_op` = 1) sends `cmd_data` least significant bit first. A read-byte command (`cmd_op` = 2) assembles `rd_data` least significant bit first. A write-bit command (`cmd_op` = 3) sends `cmd_data[0]`.
- R8: A write command with `cmd_pullup`=1 raises `pullup_en` within 10 µs after its last slot ends. `pullup_en` stays high for `hold_us` microseconds, the line is never driven low while it is high, and `busy` stays high until it ends. Without the flag, or on a read command, `pullup_en` stays 0.
- R9: A command presented while `busy` is high is ignored, and so is any `cmd_op` value of 5 to 7. No line activity follows from either.
- R10: `done` is a one-cycle pulse, and `busy` is low whenever `done` is high. A command presented in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 reset, 1 write byte, 2 read byte, 3 write bit, 4 read bit |
| cmd_data | input | DATA_W | Byte to write, or bit 0 for a write-bit command |
| cmd_pullup | input | 1 | Request the strong pullup after a write command |
| hold_us | input | HOLD_W | Strong pullup hold time in microseconds |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Received data |
| presence | output | 1 | A presence response was seen on the last reset |
| no_device | output | 1 | No presence response was seen on the last reset |
| line_drive_low | output | 1 | Pad pull-down enable |
| line_in | input | 1 | Raw line level from the pad |
| pullup_en | output | 1 | Strong pullup enable |

## Verification
Two functions can fall in one cycle: the `done` strobe of one command and the acceptance of the next. The bench provokes this by presenting the next command in the very cycle it observes `done`. It then judges the result by the bit pattern and pulse widths of the second command's slots. A second overlap is a command presented while another is busy. This is provoked both in the middle of a reset and in the middle of a byte write. It is judged by checking that no extra falling edges appear on the line and that the running command's pattern comes out intact.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_WR_BYTE = 3'd1,
        OP_RD_BYTE = 3'd2,
        OP_WR_BIT  = 3'd3,
        OP_RD_BIT  = 3'd4
    } sw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_LISTEN,
        ST_SLOT_LOW,
        ST_SLOT_REL,
        ST_RECOVER,
        ST_PULLUP
    } sw_state_e;

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // idle level of the line is high, so the chain resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/sw_us_timer.sv
module sw_us_timer #(
    parameter int CLKS_PER_US = 125,
    parameter int CNT_W       = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] us_cnt,
    output logic             us_tick,
    output logic             us_first
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

    generate
        if (CLKS_PER_US > 1) begin : g_pre
            logic [PRE_W-1:0] pre;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       pre <= '0;
                else if (clear)   pre <= '0;
                else if (us_tick) pre <= '0;
                else              pre <= pre + PRE_W'(1);
            end
            assign us_tick  = (pre == PRE_W'(CLKS_PER_US - 1));
            assign us_first = (pre == '0);

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                us_tick |=> !us_tick); // R4
        end else begin : g_nopre
            assign us_tick  = 1'b1;
            assign us_first = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       us_cnt <= '0;
        else if (clear)   us_cnt <= '0;
        else if (us_tick) us_cnt <= us_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/sw_bit_shifter.sv
module sw_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_single,
    input  logic              advance,
    input  logic              sample,
    input  logic              sample_bit,
    output logic              cur_bit,
    output logic              last_bit,
    output logic [DATA_W-1:0] rx_data
);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] tx_q;
    logic [BC_W-1:0]   cnt_q;
    logic              single_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            cnt_q    <= '0;
            single_q <= 1'b0;
        end else if (load) begin
            tx_q     <= load_data;
            cnt_q    <= '0;
            single_q <= load_single;
        end else if (advance) begin
            tx_q     <= tx_q >> 1;
            cnt_q    <= cnt_q + BC_W'(1);
        end
    end

    // received bits enter at the top, so LSB-first arrival ends aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rx_data <= '0;
        else if (sample) rx_data <= {sample_bit, rx_data[DATA_W-1:1]};
    end

    assign cur_bit  = tx_q[0];
    assign last_bit = single_q || (cnt_q == BC_W'(DATA_W - 1));

    AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load, advance})); // R7
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
    import sw_pkg::*;
#(
    parameter int CLKS_PER_US   = 125,
    parameter int RST_LOW_US    = 480,
    parameter int RST_LISTEN_US = 480,
    parameter int PRES_OPEN_US  = 15,
    parameter int PRES_CLOSE_US = 75,
    parameter int SLOT_US       = 65,
    parameter int WR0_LOW_US    = 60,
    parameter int SHORT_LOW_US  = 2,
    parameter int SAMPLE_US     = 13,
    parameter int RECOVERY_US   = 2,
    parameter int HOLD_W        = 20,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_pullup,
    input  logic [HOLD_W-1:0] hold_us,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              presence,
    output logic              no_device,
    output logic              line_drive_low,
    input  logic              line_in,
    output logic              pullup_en
);
    localparam int CNT_W = (HOLD_W > 10) ? HOLD_W : 10;

    sw_state_e         state, state_n;
    sw_op_e            op_q;
    logic              pu_q;
    logic [HOLD_W-1:0] hold_q;
    logic              pres_seen;
    logic              line_s;
    logic [CNT_W-1:0]  us_cnt;
    logic              us_tick, us_first;
    logic              clr, ld, adv, smp, finish;
    logic              cur_bit, last_bit;
    logic              is_read, is_write, cmd_ok;
    logic [CNT_W-1:0]  low_end;

    sw_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
    );

    sw_us_timer #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(clr),
        .us_cnt(us_cnt), .us_tick(us_tick), .us_first(us_first)
    );

    sw_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(ld), .load_data(cmd_data),
        .load_single(cmd_op == OP_WR_BIT || cmd_op == OP_RD_BIT),
        .advance(adv), .sample(smp), .sample_bit(line_s),
        .cur_bit(cur_bit), .last_bit(last_bit), .rx_data(rd_data)
    );

    assign cmd_ok   = cmd_valid && (cmd_op <= 3'd4);
    assign is_read  = (op_q == OP_RD_BYTE) || (op_q == OP_RD_BIT);
    assign is_write = (op_q == OP_WR_BYTE) || (op_q == OP_WR_BIT);
    assign low_end  = (is_write && !cur_bit) ? CNT_W'(WR0_LOW_US - 1)
                                             : CNT_W'(SHORT_LOW_US - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state and sequencing strobes
    always_comb begin
        state_n = state;
        clr     = 1'b0;
        ld      = 1'b0;
        adv     = 1'b0;
        smp     = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_ok) begin
                    ld      = 1'b1;
                    clr     = 1'b1;
                    state_n = (cmd_op == OP_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
                end
            end
            ST_RST_LOW: begin
                if (us_tick && us_cnt == CNT_W'(RST_LOW_US - 1)) begin
                    clr     = 1'b1;
                    state_n = ST_RST_LISTEN;
                end
            end
            ST_RST_LISTEN: begin
                if (us_tick && us_cnt == CNT_W'(RST_LISTEN_US - 1)) begin
                    finish  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_SLOT_LOW: begin
                if (us_tick && us_cnt == low_end) state_n = ST_SLOT_REL;
            end
            ST_SLOT_REL: begin
                smp = is_read && us_first && (us_cnt == CNT_W'(SAMPLE_US));
                if (us_tick && us_cnt == CNT_W'(SLOT_US - 1)) begin
                    clr     = 1'b1;
                    state_n = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (us_tick && us_cnt == CNT_W'(RECOVERY_US - 1)) begin
                    clr = 1'b1;
                    if (!last_bit) begin
                        adv     = 1'b1;
                        state_n = ST_SLOT_LOW;
                    end else if (pu_q) begin
                        state_n = ST_PULLUP;
                    end else begin
                        finish  = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_PULLUP: begin
                if (hold_q == '0 ||
                    (us_tick && us_cnt == CNT_W'(hold_q) - CNT_W'(1))) begin
                    finish  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // command capture and presence watch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_RESET;
            pu_q      <= 1'b0;
            hold_q    <= '0;
            pres_seen <= 1'b0;
        end else if (ld) begin
            op_q      <= sw_op_e'(cmd_op);
            pu_q      <= cmd_pullup && (cmd_op == OP_WR_BYTE || cmd_op == OP_WR_BIT);
            hold_q    <= hold_us;
            pres_seen <= 1'b0;
        end else if (state == ST_RST_LISTEN && !line_s &&
                     us_cnt >= CNT_W'(PRES_OPEN_US) && us_cnt < CNT_W'(PRES_CLOSE_US)) begin
            pres_seen <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            presence  <= 1'b0;
            no_device <= 1'b0;
        end else begin
            done <= finish;
            if (finish && op_q == OP_RESET) begin
                presence  <= pres_seen;
                no_device <= !pres_seen;
            end
        end
    end

    assign busy           = (state != ST_IDLE);
    assign line_drive_low = (state == ST_RST_LOW) || (state == ST_SLOT_LOW);
    assign pullup_en      = (state == ST_PULLUP);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op <= 3'd4) |=> busy); // R9
    AST_PRES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(presence && no_device)); // R3
    AST_PULLUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> (!line_drive_low && busy)); // R8
    AST_READ_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_read) |-> !pullup_en); // R8
endmodule

// File: tb/sw_bus_master_tb_top.sv
`timescale 1ns/1ps
module sw_bus_master_tb_top;
    localparam int C = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_pullup = 1'b0;
    logic [19:0] hold_us = 20'd0;
    logic       busy, done, presence, no_device, drv, spu;
    logic [7:0] rd_data;
    logic       line_in;
    logic       slave_low;

    always #4 clk = ~clk;

    sw_bus_master #(.CLKS_PER_US(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_pullup(cmd_pullup), .hold_us(hold_us),
        .busy(busy), .done(done), .rd_data(rd_data), .presence(presence),
        .no_device(no_device), .line_drive_low(drv), .line_in(line_in),
        .pullup_en(spu)
    );

    // bench-side slave settings (written only by the main process)
    int       p_start = 0, p_end = 0;
    logic [7:0] rd_pat = 8'hFF;
    int       rd_base = 0;
    int       rd_hold = 20;

    // monitor and slave state (written only by the monitor)
    logic prev_drv = 1'b0, prev_spu = 1'b0, prev_done = 1'b0;
    int   lowcnt = 0, rel_cnt = 0, last_low = 0, falls = 0;
    int   since_fall = 0, last_period = 0;
    logic [7:0] wbits = 8'd0;
    int   slot_t = 1000000;
    logic slot_bit = 1'b1;
    logic pres_act = 1'b0;
    int   pres_t = 0;
    int   spu_run = 0, last_spu = 0, spu_rises = 0, spu_gap = 0;
    logic spu_drive = 1'b0, spu_nb = 1'b0, bad_done = 1'b0, done_busy = 1'b0;

    assign slave_low = (!slot_bit && slot_t < rd_hold * C) ||
                       (pres_act && pres_t >= p_start * C && pres_t < p_end * C);
    assign line_in = !(drv || slave_low);

    always @(negedge clk) begin
        prev_drv  <= drv;
        prev_spu  <= spu;
        prev_done <= done;
        if (drv) begin lowcnt <= lowcnt + 1; rel_cnt <= 0; end
        else     begin lowcnt <= 0; rel_cnt <= rel_cnt + 1; end
        if (!drv && prev_drv) begin
            last_low <= lowcnt;
            wbits    <= {(lowcnt < 10 * C), wbits[7:1]};
            if (lowcnt >= 400 * C) begin pres_act <= 1'b1; pres_t <= 0; end
            else pres_t <= pres_t + 1;
        end else begin
            pres_t <= pres_t + 1;
        end
        if (drv && !prev_drv) begin
            falls       <= falls + 1;
            last_period <= since_fall;
            since_fall  <= 1;
            slot_t      <= 0;
            slot_bit    <= ((falls - rd_base) >= 0 && (falls - rd_base) < 8) ?
                           rd_pat[(falls - rd_base) & 7] : 1'b1;
            pres_act    <= 1'b0;
        end else begin
            since_fall <= since_fall + 1;
            slot_t     <= slot_t + 1;
        end
        if (spu) spu_run <= spu_run + 1; else spu_run <= 0;
        if (spu && !prev_spu) begin spu_rises <= spu_rises + 1; spu_gap <= rel_cnt; end
        if (!spu && prev_spu) last_spu <= spu_run;
        if (spu && drv) spu_drive <= 1'b1;
        if (spu && !busy) spu_nb <= 1'b1;
        if (done && prev_done) bad_done <= 1'b1;
        if (done && busy) done_busy <= 1'b1;
    end

    int checks = 0, errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_low(input logic b);
        return b ? 2 * C : 60 * C;
    endfunction

    task automatic send(input logic [2:0] op, input logic [7:0] d,
                        input logic pu, input int hold);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_data   = d;
        cmd_pullup = pu;
        hold_us    = 20'(hold);
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        do begin @(negedge clk); t++; end while (!done && t < 5000);
        if (!done) chk({tag, " done timeout"}, 0, 1);
        #1;
    endtask

    task automatic do_read(input logic [2:0] op, input logic [7:0] pat, input int hold);
        rd_pat  = pat;
        rd_base = falls;
        rd_hold = hold;
        send(op, 8'h00, 1'b0, 0);
        wait_done("read");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r, f0;
        logic [7:0] v;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 drive", drv, 0);
        chk("R1 pullup", spu, 0);
        chk("R1 presence", presence, 0);
        chk("R1 no_device", no_device, 0);
        chk("R1 rd_data", rd_data, 0);

        // R2/R3 reset with a normal presence response
        p_start = 30; p_end = 130;
        send(3'd0, 8'h00, 1'b0, 0);
        chk("R2 busy after accept", busy, 1);
        wait_done("R2");
        chk("R2 reset low width", last_low, 480 * C);
        chk("R2 listen length", rel_cnt, 480 * C + 1);
        chk("R3 presence", presence, 1);
        chk("R3 no_device", no_device, 0);
        chk("R10 busy low at done", busy, 0);

        // R3 no response, late response, early short response
        p_start = 0; p_end = 0;
        send(3'd0, 8'h00, 1'b0, 0); wait_done("R3a");
        chk("R3 none presence", presence, 0);
        chk("R3 none no_device", no_device, 1);
        p_start = 80; p_end = 180;
        send(3'd0, 8'h00, 1'b0, 0); wait_done("R3b");
        chk("R3 late no_device", no_device, 1);
        p_start = 3; p_end = 12;
        send(3'd0, 8'h00, 1'b0, 0); wait_done("R3c");
        chk("R3 early no_device", no_device, 1);
        p_start = 20; p_end = 90;
        send(3'd0, 8'h00, 1'b0, 0); wait_done("R3d");
        chk("R3 window presence", presence, 1);

        // R7/R4/R5 directed writes
        send(3'd1, 8'hA5, 1'b0, 0); wait_done("R7a");
        chk("R7 write pattern A5", wbits, 8'hA5);
        chk("R4 write-1 low width", last_low, exp_low(1'b1));
        chk("R4 slot period", last_period, 67 * C);
        chk("R3 flags held", presence, 1);
        send(3'd1, 8'h00, 1'b0, 0); wait_done("R5");
        chk("R5 write-0 low width", last_low, exp_low(1'b0));
        chk("R7 write pattern 00", wbits, 8'h00);
        send(3'd3, 8'h01, 1'b0, 0); wait_done("R7b");
        chk("R7 write bit 1", last_low, exp_low(1'b1));
        send(3'd3, 8'hFE, 1'b0, 0); wait_done("R7c");
        chk("R7 write bit 0", last_low, exp_low(1'b0));

        // R6/R7 reads
        do_read(3'd2, 8'h3C, 20);
        chk("R6 read byte 3C", rd_data, 8'h3C);
        chk("R6 read low width", last_low, 2 * C);
        do_read(3'd4, 8'h00, 10);
        chk("R6 short hold reads 1", rd_data[7], 1);
        do_read(3'd4, 8'h00, 15);
        chk("R6 hold past sample reads 0", rd_data[7], 0);

        // R8 strong pullup
        send(3'd1, 8'h44, 1'b1, 50); wait_done("R8a");
        chk("R8 pullup length", last_spu, 50 * C);
        chk("R8 pullup starts within 10us", (spu_gap <= 10 * C) ? 1 : 0, 1);
        chk("R8 byte before pullup", wbits, 8'h44);
        r = spu_rises;
        send(3'd1, 8'h48, 1'b0, 50); wait_done("R8b");
        do_read(3'd2, 8'hFF, 20);
        chk("R8 no pullup without flag", spu_rises, r);

        // R9 commands while busy and invalid codes
        send(3'd0, 8'h00, 1'b0, 0);
        repeat (100) @(negedge clk);
        send(3'd1, 8'h00, 1'b0, 0);
        wait_done("R9a");
        f0 = falls;
        chk("R9 reset not disturbed", last_low, 480 * C);
        repeat (300) @(negedge clk);
        chk("R9 ignored write made no slots", falls, f0);
        send(3'd1, 8'h96, 1'b0, 0);
        repeat (200) @(negedge clk);
        send(3'd0, 8'h00, 1'b0, 0);
        wait_done("R9b");
        chk("R9 byte kept during busy reset cmd", wbits, 8'h96);
        f0 = falls;
        send(3'd5, 8'h00, 1'b0, 0);
        repeat (20) @(negedge clk);
        chk("R9 op 5 ignored busy", busy, 0);
        chk("R9 op 5 ignored line", falls, f0);

        // random traffic; each command is issued in the done cycle (R10)
        send(3'd1, 8'h11, 1'b0, 0); wait_done("R10 lead");
        for (int i = 0; i < 6; i++) begin
            v = 8'($urandom);
            chk("R10 done seen before next", done, 1);
            send(3'd1, v, 1'b0, 0); wait_done("R7 rnd wr");
            chk("R7 random write", wbits, v);
        end
        for (int i = 0; i < 4; i++) begin
            v = 8'($urandom);
            do_read(3'd2, v, 20);
            chk("R7 random read", rd_data, v);
        end

        chk("R10 done one cycle", bad_done, 0);
        chk("R10 done with busy", done_busy, 0);
        chk("R8 drive during pullup", spu_drive, 0);
        chk("R8 busy during pullup", spu_nb, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule